// File: doc/BRIEF.md
# Open-Circuit Fault Detect-and-Locate Sequencer

This block runs the supervisory procedure that sits beside a circulating-current observer in a converter with two arms of cells. It receives one sample strobe per control period. With each strobe it gets the magnitude of the observer error, the measured circulating current and the two arm currents. While it is watching for faults, it declares one only when the error stays above a load-dependent detection threshold for a run of consecutive samples. It then starts testing hypotheses. Each candidate device, a cell and one of its two switches, is presented to the observer in turn. The observer substitutes the switching state for that candidate. The sequencer drops the candidate as soon as the error exceeds a second, lower threshold. It accepts the candidate once a full verification window passes with no such excursion.

The sequencer asks the observer to copy the measurement into its estimate in two cases: on every new hypothesis, and on every sample in which the assumed faulty arm carries no current, because the state cannot be observed then. A candidate that is accepted is held on the outputs until reset. If no candidate is accepted, a one-clock flag is raised and the block returns to watching. Both thresholds are derived inside the block from the magnitude of the measured circulating current, with floors tied to the full-load current.

Top module: `fdi_sequencer`

## Requirements
- R1: After reset the block is in detection: `isolating`, `resync_req`, `fault_located` and `unresolved` are 0, and `hyp_idx` and `fault_idx` are 0.
- R2: With current magnitude |iz| in current LSBs, the detection threshold is max(2·|iz|, FULL_LOAD/2) and the verification threshold is max(|iz|, FULL_LOAD/4). Integer division truncates. An error counts as exceeding a threshold only when it is strictly greater than it. At the defaults (FULL_LOAD = 52), |iz| = 52 gives 104 and 52.
- R3: Isolation starts one clock after the PERSIST_SAMPLES-th consecutive sample whose error exceeds the detection threshold. Any sample that does not exceed it restarts the run.
- R4: Candidates are numbered by a 4-bit index. Bits [3:1] give the cell (0..7) and bit 0 gives the switch. Cells 0..3 belong to the upper arm and cells 4..7 to the lower arm. Isolation starts at index 0, and each rejection moves to the next index.
- R5: A sample in isolation whose error exceeds the verification threshold rejects the current candidate. An error equal to the threshold does not.
- R6: After WINDOW_SAMPLES consecutive non-rejecting samples on one candidate, `fault_located` goes to 1 and `fault_idx` shows that candidate. Both hold until reset, whatever later samples carry, and `isolating` drops.
- R7: `resync_req` is high for exactly one clock after each sample that enters a new candidate, including the first.
- R8: In isolation, a sample that keeps the same candidate, and in which the assumed arm's current magnitude is at most ZERO_BAND (default 0), produces a one-clock `resync_req`. It produces none when only the other arm is zero.
- R9: Rejecting the last candidate (index 15) gives a one-clock `unresolved` pulse, a return to detection with index 0, and a fresh persistence run.
- R10: Clocks without `sample_valid` change no output and request no resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-clock strobe marking a new sample |
| err_mag | input | CUR_W | Unsigned observer error magnitude |
| iz_meas | input | CUR_W | Signed measured circulating current |
| arm_upper | input | CUR_W | Signed upper arm current |
| arm_lower | input | CUR_W | Signed lower arm current |
| isolating | output | 1 | High while candidates are being tested |
| hyp_idx | output | IDX_W | Candidate under test (cell in [3:1], switch in [0]) |
| resync_req | output | 1 | One-clock request to copy the measurement into the estimate |
| fault_located | output | 1 | Candidate accepted; held until reset |
| fault_idx | output | IDX_W | Accepted candidate index, 0 when none |
| unresolved | output | 1 | One-clock pulse after all candidates are rejected |

## Verification
The bound checker watches the properties that hold on every cycle. The candidate index only ever steps up by one while isolating. An accepted result is terminal and stable. The unresolved flag lasts a single clock and coincides with a return to detection. A resync request appears only during isolation and only after a strobe, and the index never moves on clocks without a strobe. Only the bench's scenarios can show the quantities tied to data and time. These are where the two thresholds fall for different currents, the exact persistence length and its restart, the arm selection that triggers a resync, and the exact sample on which the verification window expires.

// File: rtl/fdi_pkg.sv
package fdi_pkg;
    typedef enum logic [1:0] {
        SEQ_DETECT  = 2'd0,
        SEQ_ISOLATE = 2'd1,
        SEQ_LOCATED = 2'd2
    } seq_mode_e;
endpackage

// File: rtl/fdi_thresholds.sv
// Load-following detection and verification thresholds with floors.
module fdi_thresholds #(
    parameter int CUR_W     = 12,
    parameter int FULL_LOAD = 52
) (
    input  logic signed [CUR_W-1:0] iz,
    output logic        [CUR_W:0]   th_detect,
    output logic        [CUR_W:0]   th_verify
);
    localparam int TH_W = CUR_W + 1;
    localparam logic [TH_W-1:0] FLOOR_DET = TH_W'(FULL_LOAD / 2);
    localparam logic [TH_W-1:0] FLOOR_VER = TH_W'(FULL_LOAD / 4);

    logic signed [TH_W-1:0] iz_ext;
    logic        [TH_W-1:0] iz_mag;
    logic        [TH_W-1:0] iz_twice;

    always_comb begin
        iz_ext    = TH_W'(iz);
        iz_mag    = iz_ext[TH_W-1] ? TH_W'(-iz_ext) : TH_W'(iz_ext);
        iz_twice  = {iz_mag[TH_W-2:0], 1'b0};
        th_detect = (iz_twice > FLOOR_DET) ? iz_twice : FLOOR_DET;
        th_verify = (iz_mag   > FLOOR_VER) ? iz_mag   : FLOOR_VER;
    end
endmodule

// File: rtl/fdi_run_counter.sv
// Counts strobed events; at_last flags that the next event completes the run.
module fdi_run_counter #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)      count_d = '0;
        else if (inc) count_d = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign at_last = (count_q == LAST);
endmodule

// File: rtl/fdi_sequencer.sv
// Detect-then-locate sequencer for open-circuit switch faults.
module fdi_sequencer
    import fdi_pkg::*;
#(
    parameter int CUR_W           = 12,
    parameter int NUM_CELLS       = 8,
    parameter int PERSIST_SAMPLES = 40,
    parameter int WINDOW_SAMPLES  = 5000,
    parameter int FULL_LOAD       = 52,
    parameter int ZERO_BAND       = 0,
    localparam int NUM_CAND       = 2 * NUM_CELLS,
    localparam int IDX_W          = $clog2(NUM_CAND)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_valid,
    input  logic        [CUR_W-1:0] err_mag,
    input  logic signed [CUR_W-1:0] iz_meas,
    input  logic signed [CUR_W-1:0] arm_upper,
    input  logic signed [CUR_W-1:0] arm_lower,
    output logic                    isolating,
    output logic        [IDX_W-1:0] hyp_idx,
    output logic                    resync_req,
    output logic                    fault_located,
    output logic        [IDX_W-1:0] fault_idx,
    output logic                    unresolved
);
    localparam int CELL_W      = IDX_W - 1;
    localparam int UPPER_CELLS = NUM_CELLS / 2;
    localparam int TH_W        = CUR_W + 1;
    localparam logic [IDX_W-1:0]  LAST_CAND = IDX_W'(NUM_CAND - 1);
    localparam logic [CELL_W-1:0] FIRST_LOW = CELL_W'(UPPER_CELLS);
    localparam logic [TH_W-1:0]   BAND      = TH_W'(ZERO_BAND);

    typedef struct packed {
        seq_mode_e        mode;
        logic [IDX_W-1:0] hyp;
        logic             resync;
        logic             unres;
    } seq_t;

    seq_t st_d, st_q;

    logic [TH_W-1:0] th_det, th_ver;
    logic [TH_W-1:0] err_ext;
    logic            over_det, over_ver;
    logic            pers_inc, pers_clr, pers_last;
    logic            win_inc, win_clr, win_last;
    logic signed [TH_W-1:0] arm_sel;
    logic        [TH_W-1:0] arm_mag;
    logic            arm_is_low, arm_zero;

    fdi_thresholds #(.CUR_W(CUR_W), .FULL_LOAD(FULL_LOAD)) u_thr (
        .iz(iz_meas), .th_detect(th_det), .th_verify(th_ver)
    );

    fdi_run_counter #(.LIMIT(PERSIST_SAMPLES)) u_persist (
        .clk(clk), .rst_n(rst_n), .clr(pers_clr), .inc(pers_inc), .at_last(pers_last)
    );

    fdi_run_counter #(.LIMIT(WINDOW_SAMPLES)) u_window (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .inc(win_inc), .at_last(win_last)
    );

    // Error comparisons and assumed-arm current test.
    always_comb begin
        err_ext    = {1'b0, err_mag};
        over_det   = err_ext > th_det;
        over_ver   = err_ext > th_ver;
        arm_is_low = st_q.hyp[IDX_W-1:1] >= FIRST_LOW;
        arm_sel    = arm_is_low ? TH_W'(arm_lower) : TH_W'(arm_upper);
        arm_mag    = arm_sel[TH_W-1] ? TH_W'(-arm_sel) : TH_W'(arm_sel);
        arm_zero   = arm_mag <= BAND;
    end

    // Run counter controls.
    always_comb begin
        pers_inc = sample_valid && (st_q.mode == SEQ_DETECT) && over_det;
        pers_clr = (st_q.mode != SEQ_DETECT) || (sample_valid && !over_det)
                   || (pers_inc && pers_last);
        win_inc  = sample_valid && (st_q.mode == SEQ_ISOLATE) && !over_ver;
        win_clr  = (st_q.mode != SEQ_ISOLATE) || (sample_valid && over_ver)
                   || (win_inc && win_last);
    end

    // Sequencer next state.
    always_comb begin
        st_d        = st_q;
        st_d.resync = 1'b0;
        st_d.unres  = 1'b0;
        unique case (st_q.mode)
            SEQ_DETECT: begin
                if (pers_inc && pers_last) begin
                    st_d.mode   = SEQ_ISOLATE;
                    st_d.hyp    = '0;
                    st_d.resync = 1'b1;
                end
            end
            SEQ_ISOLATE: begin
                if (sample_valid) begin
                    if (over_ver) begin
                        if (st_q.hyp == LAST_CAND) begin
                            st_d.mode  = SEQ_DETECT;
                            st_d.hyp   = '0;
                            st_d.unres = 1'b1;
                        end else begin
                            st_d.hyp    = st_q.hyp + IDX_W'(1);
                            st_d.resync = 1'b1;
                        end
                    end else if (win_last) begin
                        st_d.mode = SEQ_LOCATED;
                    end else if (arm_zero) begin
                        st_d.resync = 1'b1;
                    end
                end
            end
            SEQ_LOCATED: begin
                st_d = st_q;
            end
            default: begin
                st_d.mode = SEQ_DETECT;
                st_d.hyp  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= SEQ_DETECT;
            st_q.hyp    <= '0;
            st_q.resync <= 1'b0;
            st_q.unres  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign isolating     = (st_q.mode == SEQ_ISOLATE);
    assign hyp_idx       = st_q.hyp;
    assign resync_req    = st_q.resync;
    assign fault_located = (st_q.mode == SEQ_LOCATED);
    assign fault_idx     = (st_q.mode == SEQ_LOCATED) ? st_q.hyp : '0;
    assign unresolved    = st_q.unres;
endmodule

// File: rtl/fdi_sequencer_chk.sv
// Protocol properties of the sequencer outputs.
module fdi_sequencer_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             isolating,
    input logic [IDX_W-1:0] hyp_idx,
    input logic             resync_req,
    input logic             fault_located,
    input logic [IDX_W-1:0] fault_idx,
    input logic             unresolved
);
    a_r4_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (isolating && $past(isolating) && hyp_idx != $past(hyp_idx))
        |-> hyp_idx == $past(hyp_idx) + IDX_W'(1));

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        fault_located |=> fault_located && $stable(fault_idx));

    a_r6_result_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
        fault_located |-> !isolating && !resync_req && !unresolved);

    a_r9_unresolved_single: assert property (@(posedge clk) disable iff (!rst_n)
        unresolved |=> !unresolved);

    a_r9_unresolved_back_to_watch: assert property (@(posedge clk) disable iff (!rst_n)
        unresolved |-> !isolating && !fault_located && hyp_idx == '0);

    a_r7_resync_while_isolating: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |-> isolating);

    a_r10_resync_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |-> $past(sample_valid));

    a_r10_index_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_valid) |-> $stable(hyp_idx));
endmodule

bind fdi_sequencer fdi_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .isolating(isolating), .hyp_idx(hyp_idx), .resync_req(resync_req),
    .fault_located(fault_located), .fault_idx(fault_idx), .unresolved(unresolved)
);

// File: tb/sim_fdi_sequencer.sv
module sim_fdi_sequencer;
    localparam int CUR_W  = 12;
    localparam int PERS   = 40;
    localparam int WIN    = 5000;
    localparam int NVEC   = 8;
    // Threshold vectors: current, error, whether isolation follows a full run.
    localparam int VEC_IZ [NVEC] = '{52, 52, -52, 5, 5, 0, 20, 20};
    localparam int VEC_ERR[NVEC] = '{105, 104, 105, 27, 26, 27, 41, 40};
    localparam int VEC_EXP[NVEC] = '{1, 0, 1, 1, 0, 1, 1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic        [CUR_W-1:0] err_mag = '0;
    logic signed [CUR_W-1:0] iz_meas = '0;
    logic signed [CUR_W-1:0] arm_upper = '0;
    logic signed [CUR_W-1:0] arm_lower = '0;
    logic       isolating, resync_req, fault_located, unresolved;
    logic [3:0] hyp_idx, fault_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fdi_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .err_mag(err_mag),
        .iz_meas(iz_meas), .arm_upper(arm_upper), .arm_lower(arm_lower),
        .isolating(isolating), .hyp_idx(hyp_idx), .resync_req(resync_req),
        .fault_located(fault_located), .fault_idx(fault_idx), .unresolved(unresolved)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One strobed sample; returns at the negedge after the registering edge.
    task automatic smp(input int e, input int z, input int u, input int l);
        @(negedge clk);
        err_mag = CUR_W'(e);
        iz_meas = CUR_W'(z);
        arm_upper = CUR_W'(u);
        arm_lower = CUR_W'(l);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic smpn(input int n, input int e, input int z, input int u, input int l);
        for (int k = 0; k < n; k++) smp(e, z, u, l);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 isolating", isolating, 0);
        chk("R1 hyp_idx", hyp_idx, 0);
        chk("R1 resync_req", resync_req, 0);
        chk("R1 fault_located", fault_located, 0);
        chk("R1 fault_idx", fault_idx, 0);
        chk("R1 unresolved", unresolved, 0);

        // R2 / R3 threshold table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            smpn(PERS - 1, VEC_ERR[v], VEC_IZ[v], 30, -30);
            chk("R3 no entry before full run", isolating, 0);
            smp(VEC_ERR[v], VEC_IZ[v], 30, -30);
            chk("R2 threshold vector", isolating, VEC_EXP[v]);
        end

        // R3 run restarts on a non-exceeding sample
        do_reset();
        smpn(PERS - 1, 200, 52, 30, -30);
        smp(104, 52, 30, -30);
        smpn(PERS - 1, 200, 52, 30, -30);
        chk("R3 restart after break", isolating, 0);
        smp(200, 52, 30, -30);
        chk("R3 entry on full run", isolating, 1);
        chk("R4 first candidate", hyp_idx, 0);
        chk("R7 resync on entry", resync_req, 1);
        @(negedge clk);
        chk("R7 resync one clock", resync_req, 0);

        // R5 rejection, R7 resync on new candidate
        smp(53, 52, 30, -30);
        chk("R5 reject above th2", hyp_idx, 1);
        chk("R7 resync on next candidate", resync_req, 1);
        smp(52, 52, 30, 0);
        chk("R5 equal th2 keeps candidate", hyp_idx, 1);
        chk("R8 other arm zero no resync", resync_req, 0);
        smp(10, 52, 0, 30);
        chk("R8 upper arm zero resync", resync_req, 1);
        smpn(7, 60, 52, 30, -30);
        chk("R4 index after rejections", hyp_idx, 8);
        smp(10, 52, 30, 0);
        chk("R8 lower arm zero resync", resync_req, 1);
        smp(10, 52, 0, 30);
        chk("R8 upper zero for lower cell", resync_req, 0);

        // R10 idle clocks have no effect
        @(negedge clk);
        err_mag = CUR_W'(4000);
        arm_upper = '0;
        arm_lower = '0;
        repeat (10) @(negedge clk);
        chk("R10 idle index", hyp_idx, 8);
        chk("R10 idle mode", isolating, 1);
        chk("R10 idle resync", resync_req, 0);

        // R6 window: two non-rejecting samples already on candidate 8
        smpn(WIN - 3, 10, 52, 30, -30);
        chk("R6 window not yet complete", fault_located, 0);
        smp(10, 52, 30, -30);
        chk("R6 located", fault_located, 1);
        chk("R6 located index", fault_idx, 8);
        chk("R6 search ended", isolating, 0);
        smpn(3, 4000, 52, 0, 0);
        chk("R6 result held", fault_located, 1);
        chk("R6 index held", fault_idx, 8);

        // R9 all candidates rejected
        do_reset();
        smpn(PERS, 200, 52, 30, -30);
        smpn(15, 200, 52, 30, -30);
        chk("R9 last candidate", hyp_idx, 15);
        smp(200, 52, 30, -30);
        chk("R9 unresolved", unresolved, 1);
        chk("R9 back to detection", isolating, 0);
        chk("R9 index cleared", hyp_idx, 0);
        @(negedge clk);
        chk("R9 unresolved one clock", unresolved, 0);
        smpn(PERS - 1, 200, 52, 30, -30);
        chk("R9 fresh persistence run", isolating, 0);
        smp(200, 52, 30, -30);
        chk("R9 re-entry after full run", isolating, 1);

        finish_run();
    end
endmodule